// File: doc/BRIEF.md
# Serial EEPROM Boot Image Reader

This block is a two-wire bus master that runs exactly once after reset. It copies a boot image out of a serial EEPROM and hands the bytes to the logic behind it. It first sets the EEPROM's internal address pointer to 0 with a dummy write. It then turns the bus around with a repeated START and performs one sequential read. That read continues until a byte count, sampled when reset is released, has been delivered.

Each received byte appears for a single clock cycle on a data/valid/index output. The master acknowledges every byte except the final one. It ends the transfer with NACK and STOP, then pulses `done_o`. If the EEPROM fails to acknowledge any address byte, the block stops the transfer, raises a sticky error flag and pulses `done_o` without delivering data.

The bit rate comes from a parameterised divider of the system clock. Every bit is built from four equal quarter phases. SCL is driven push-pull. SDA is driven open-drain, using an output enable that pulls the line low and a separate input that reads the line back.

Top module: `i2c_boot_reader`

## Requirements
- R1: After reset the first frame is a START, then the byte 0xA0 (7-bit device address 1010000 followed by R/W=0, most significant bit first), then the word address byte 0x00.
- R2: After the word address the master issues a repeated START with no STOP in between, then sends the byte 0xA1 (same device address, R/W=1).
- R3: Data bytes are shifted in most significant bit first. Each one is presented for exactly one clock cycle with `data_valid_o` high, and `data_index_o` counts from 0 up by one per byte.
- R4: The master drives ACK (SDA low in the ninth bit) after every received byte except the last. After the last byte it leaves SDA high (NACK) and then generates STOP. A one-byte read therefore NACKs its first byte.
- R5: `byte_count_i` is sampled once, in the first cycle after reset is released, and later changes have no effect on the number of bytes read. A sampled value of 0 is treated as 1.
- R6: If any of the three address bytes (0xA0, 0x00, 0xA1) is not acknowledged, the master generates STOP and delivers no data. `error_o` rises and stays high until the next reset.
- R7: `done_o` pulses for one cycle once STOP has completed. While reset is held, at `done_o`, and ever after it, SCL is high, SDA is released and no further bus activity or data output occurs.
- R8: SDA changes while SCL is high only to form START, repeated START or STOP. A normal run therefore shows exactly two SDA falls and one SDA rise while SCL is high.
- R9: Every SCL high period that ends in a falling edge lasts exactly 2*DIV_Q clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| byte_count_i | input | COUNT_W | Number of image bytes to read, sampled at start |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_o | output | 1 | Bus clock |
| sda_oe_o | output | 1 | Pull SDA low when 1, release when 0 |
| data_valid_o | output | 1 | One-cycle strobe for a received byte |
| data_o | output | 8 | Received byte |
| data_index_o | output | COUNT_W | Position of the byte in the image, from 0 |
| done_o | output | 1 | One-cycle pulse after the final STOP |
| error_o | output | 1 | Sticky flag for a missing address acknowledge |

## Verification
The sequence is driven against a behavioural EEPROM model whose contents are a salted function of the address. It is run with random image lengths and salts, which separate a correct MSB-first shift and index count from swapped or off-by-one variants. Lengths of one and two bytes, and a count of zero, isolate the last-byte NACK decision from the ACK path. A count changed mid-run shows whether the count was sampled only at start. Withholding the acknowledge on each of the three address bytes in turn shows that the error path stops at the right frame, with one or two STARTs and a single STOP.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  typedef enum logic [1:0] {BC_START, BC_STOP, BC_BIT} bit_cmd_e;
  typedef enum logic [1:0] {OP_START, OP_STOP, OP_WRITE, OP_READ} byte_op_e;
  typedef enum logic [3:0] {
    T_INIT, T_START, T_DEVW, T_WADDR, T_RSTART, T_DEVR, T_READ, T_STOP, T_END
  } seq_state_e;
endpackage

// File: rtl/ibr_bit_engine.sv
module ibr_bit_engine
  import ibr_pkg::*;
#(
  parameter int unsigned DIV_Q = 63
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     go_i,
  input  bit_cmd_e cmd_i,
  input  logic     bit_i,
  input  logic     sda_i,
  output logic     done_o,
  output logic     rx_o,
  output logic     scl_o,
  output logic     sda_oe_o
);
  localparam int unsigned CW = (DIV_Q > 1) ? $clog2(DIV_Q) : 1;

  logic [CW-1:0] cnt_q;
  logic [1:0]    phase_q;
  bit_cmd_e      cmd_q;
  logic          bit_q, busy_q, done_q, rx_q;
  logic          tick;

  assign tick = (cnt_q == CW'(DIV_Q - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 2'd3;
      cmd_q   <= BC_STOP;
      bit_q   <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rx_q    <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (go_i) begin
          busy_q  <= 1'b1;
          cmd_q   <= cmd_i;
          bit_q   <= bit_i;
          phase_q <= 2'd0;
          cnt_q   <= '0;
        end
      end else if (tick) begin
        cnt_q <= '0;
        if (phase_q == 2'd1) rx_q <= sda_i;  // mid-high sample
        if (phase_q == 2'd3) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          phase_q <= phase_q + 2'd1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // idle holds the last phase of the last command
  always_comb begin
    scl_o    = 1'b1;
    sda_oe_o = 1'b0;
    unique case (cmd_q)
      BC_START: begin
        scl_o    = (phase_q == 2'd1) || (phase_q == 2'd2);
        sda_oe_o = phase_q[1];
      end
      BC_STOP: begin
        scl_o    = (phase_q != 2'd0);
        sda_oe_o = !phase_q[1];
      end
      default: begin
        scl_o    = (phase_q == 2'd1) || (phase_q == 2'd2);
        sda_oe_o = !bit_q;
      end
    endcase
  end

  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/ibr_byte_engine.sv
module ibr_byte_engine
  import ibr_pkg::*;
#(
  parameter int unsigned DIV_Q = 63
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  byte_op_e   op_i,
  input  logic [7:0] wdata_i,
  input  logic       ack_i,
  input  logic       sda_i,
  output logic       done_o,
  output logic [7:0] rdata_o,
  output logic       nack_o,
  output logic       scl_o,
  output logic       sda_oe_o
);
  byte_op_e   op_q;
  logic [7:0] sh_q;
  logic [3:0] bcnt_q;
  logic       ack_q, busy_q, bgo_q, done_q, nack_q;
  bit_cmd_e   bcmd;
  logic       bbit, last_bit, bit_done, bit_rx;

  assign last_bit = (bcnt_q == 4'd8);

  always_comb begin
    bcmd = BC_BIT;
    bbit = 1'b1;
    unique case (op_q)
      OP_START: bcmd = BC_START;
      OP_STOP:  bcmd = BC_STOP;
      OP_WRITE: bbit = last_bit ? 1'b1 : sh_q[7];
      default:  bbit = last_bit ? !ack_q : 1'b1;
    endcase
  end

  ibr_bit_engine #(.DIV_Q(DIV_Q)) u_bit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (bgo_q),
    .cmd_i   (bcmd),
    .bit_i   (bbit),
    .sda_i   (sda_i),
    .done_o  (bit_done),
    .rx_o    (bit_rx),
    .scl_o   (scl_o),
    .sda_oe_o(sda_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_STOP;
      sh_q   <= '0;
      bcnt_q <= '0;
      ack_q  <= 1'b0;
      busy_q <= 1'b0;
      bgo_q  <= 1'b0;
      done_q <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      bgo_q  <= 1'b0;
      done_q <= 1'b0;
      if (go_i && !busy_q) begin
        busy_q <= 1'b1;
        op_q   <= op_i;
        sh_q   <= wdata_i;
        ack_q  <= ack_i;
        bcnt_q <= '0;
        bgo_q  <= 1'b1;
      end else if (busy_q && bit_done) begin
        if (op_q == OP_START || op_q == OP_STOP) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (last_bit) begin
          nack_q <= bit_rx;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          sh_q   <= {sh_q[6:0], bit_rx};
          bcnt_q <= bcnt_q + 4'd1;
          bgo_q  <= 1'b1;
        end
      end
    end
  end

  assign done_o  = done_q;
  assign rdata_o = sh_q;
  assign nack_o  = nack_q;
endmodule

// File: rtl/i2c_boot_reader.sv
module i2c_boot_reader
  import ibr_pkg::*;
#(
  parameter int unsigned DIV_Q    = 63,
  parameter int unsigned COUNT_W  = 16,
  parameter logic [6:0]  DEV_ADDR = 7'b1010000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [COUNT_W-1:0] byte_count_i,
  input  logic               sda_i,
  output logic               scl_o,
  output logic               sda_oe_o,
  output logic               data_valid_o,
  output logic [7:0]         data_o,
  output logic [COUNT_W-1:0] data_index_o,
  output logic               done_o,
  output logic               error_o
);
  localparam logic [7:0] WORD_ADDR = 8'h00;

  seq_state_e         state_q;
  logic [COUNT_W-1:0] cnt_q, idx_q, index_q;
  logic [7:0]         data_q, wdata, rdata;
  logic               go_q, valid_q, done_q, err_q;
  logic               bdone, bnack, last;
  byte_op_e           op;

  assign last = (idx_q == cnt_q - 1'b1);

  always_comb begin
    op    = OP_WRITE;
    wdata = WORD_ADDR;
    unique case (state_q)
      T_START, T_RSTART: op = OP_START;
      T_STOP:            op = OP_STOP;
      T_READ:            op = OP_READ;
      T_DEVW:            wdata = {DEV_ADDR, 1'b0};
      T_DEVR:            wdata = {DEV_ADDR, 1'b1};
      default:           op = OP_WRITE;
    endcase
  end

  ibr_byte_engine #(.DIV_Q(DIV_Q)) u_byte (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go_q),
    .op_i    (op),
    .wdata_i (wdata),
    .ack_i   (!last),
    .sda_i   (sda_i),
    .done_o  (bdone),
    .rdata_o (rdata),
    .nack_o  (bnack),
    .scl_o   (scl_o),
    .sda_oe_o(sda_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= T_INIT;
      cnt_q   <= '0;
      idx_q   <= '0;
      index_q <= '0;
      data_q  <= '0;
      go_q    <= 1'b0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      go_q    <= 1'b0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      if (state_q == T_INIT) begin
        cnt_q   <= (byte_count_i == '0) ? COUNT_W'(1) : byte_count_i;
        state_q <= T_START;
        go_q    <= 1'b1;
      end else if (bdone) begin
        go_q <= (state_q != T_STOP) && (state_q != T_END);
        unique case (state_q)
          T_START:  state_q <= T_DEVW;
          T_DEVW:   if (bnack) begin err_q <= 1'b1; state_q <= T_STOP; end
                    else state_q <= T_WADDR;
          T_WADDR:  if (bnack) begin err_q <= 1'b1; state_q <= T_STOP; end
                    else state_q <= T_RSTART;
          T_RSTART: state_q <= T_DEVR;
          T_DEVR:   if (bnack) begin err_q <= 1'b1; state_q <= T_STOP; end
                    else state_q <= T_READ;
          T_READ: begin
            valid_q <= 1'b1;
            data_q  <= rdata;
            index_q <= idx_q;
            if (last) state_q <= T_STOP;
            else idx_q <= idx_q + 1'b1;
          end
          T_STOP: begin
            done_q  <= 1'b1;
            state_q <= T_END;
          end
          default: state_q <= state_q;
        endcase
      end
    end
  end

  assign data_valid_o = valid_q;
  assign data_o       = data_q;
  assign data_index_o = index_q;
  assign done_o       = done_q;
  assign error_o      = err_q;
endmodule

// File: rtl/ibr_checker.sv
module ibr_checker #(
  parameter int unsigned COUNT_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scl_o,
  input logic               sda_oe_o,
  input logic               data_valid_o,
  input logic [COUNT_W-1:0] data_index_o,
  input logic               done_o,
  input logic               error_o
);
  logic               seen_q, done_seen_q;
  logic [COUNT_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q      <= 1'b0;
      done_seen_q <= 1'b0;
      last_q      <= '0;
    end else begin
      if (data_valid_o) begin
        seen_q <= 1'b1;
        last_q <= data_index_o;
      end
      if (done_o) done_seen_q <= 1'b1;
    end
  end

  assert_valid_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |=> !data_valid_o);
  assert_first_index_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_o && !seen_q) |-> (data_index_o == '0));
  assert_index_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_o && seen_q) |-> (data_index_o == last_q + 1'b1));
  assert_error_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o);
  assert_no_data_on_error_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !data_valid_o);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_bus_free_at_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (scl_o && !sda_oe_o));
  assert_quiet_after_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_seen_q |-> (scl_o && !sda_oe_o && !data_valid_o && !done_o));
endmodule

bind i2c_boot_reader ibr_checker #(.COUNT_W(COUNT_W)) u_ibr_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_o       (scl_o),
  .sda_oe_o    (sda_oe_o),
  .data_valid_o(data_valid_o),
  .data_index_o(data_index_o),
  .done_o      (done_o),
  .error_o     (error_o)
);

// File: tb/i2c_boot_reader_tb_top.sv
module i2c_boot_reader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 3;
  localparam int M_IDLE = 0, M_ADDR = 1, M_WA = 2, M_RD = 3, M_WD = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] byte_count_i = 16'd1;
  logic        sda_bus, scl_o, sda_oe_o, data_valid_o, done_o, error_o;
  logic [7:0]  data_o;
  logic [15:0] data_index_o;
  logic        slave_low = 1'b0;

  assign sda_bus = !(sda_oe_o || slave_low);

  i2c_boot_reader #(.DIV_Q(Q), .COUNT_W(16)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_count_i(byte_count_i),
    .sda_i       (sda_bus),
    .scl_o       (scl_o),
    .sda_oe_o    (sda_oe_o),
    .data_valid_o(data_valid_o),
    .data_o      (data_o),
    .data_index_o(data_index_o),
    .done_o      (done_o),
    .error_o     (error_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_checks = 0, n_fail = 0;
  logic [7:0] salt;
  int nack_sel;
  int mode, bitcnt, ptr, wn, starts, stops, stops_at_rs, macks, mnacks;
  int rx_cnt, done_cnt, hi_cnt, hi_bad, falls_after_done;
  logic mack, rd_next, first_hi, scl_prev, sda_prev;
  logic [7:0] sh;
  logic [7:0] wlog [0:7];

  function automatic logic [7:0] mem_byte(input int a, input logic [7:0] s);
    return 8'(a * 29 + (a >> 2)) ^ s;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // EEPROM model and output monitor, sampled mid-cycle
  always @(negedge clk_i) begin
    logic scl, sda;
    logic [7:0] b;
    if (rst_ni) begin
      scl = scl_o;
      sda = sda_bus;
      if (scl) hi_cnt++;
      if (scl_prev && !scl) begin
        if (!first_hi && hi_cnt != 2*Q) hi_bad++;
        first_hi = 1'b0;
        hi_cnt = 0;
        if (done_cnt > 0) falls_after_done++;
      end
      if (scl && scl_prev && sda_prev && !sda) begin
        starts++;
        if (starts == 2) stops_at_rs = stops;
        mode = M_ADDR; bitcnt = -1; slave_low = 1'b0;
      end else if (scl && scl_prev && !sda_prev && sda) begin
        stops++;
        mode = M_IDLE; slave_low = 1'b0;
      end else if (!scl_prev && scl && mode != M_IDLE) begin
        if (mode != M_RD && bitcnt >= 0 && bitcnt < 8) sh = {sh[6:0], sda};
        if (mode == M_RD && bitcnt == 8) begin
          mack = !sda;
          if (!sda) macks++; else mnacks++;
        end
      end else if (scl_prev && !scl && mode != M_IDLE) begin
        bitcnt++;
        if (bitcnt == 8) begin
          if (mode != M_RD) begin
            if (wn < 8) wlog[wn] = sh;
            wn++;
            if (wn == nack_sel) begin
              slave_low = 1'b0; mode = M_IDLE;
            end else begin
              slave_low = 1'b1;
              if (mode == M_ADDR) rd_next = sh[0];
              if (mode == M_WA) ptr = int'(sh);
            end
          end else begin
            slave_low = 1'b0;
          end
        end else if (bitcnt == 9) begin
          bitcnt = 0;
          case (mode)
            M_ADDR: mode = rd_next ? M_RD : M_WA;
            M_WA:   mode = M_WD;
            M_RD:   if (!mack) mode = M_IDLE; else ptr++;
            default: mode = mode;
          endcase
          b = mem_byte(ptr, salt);
          slave_low = (mode == M_RD) ? !b[7] : 1'b0;
        end else if (mode == M_RD && bitcnt >= 1 && bitcnt <= 7) begin
          b = mem_byte(ptr, salt);
          slave_low = !b[7 - bitcnt];
        end
      end
      scl_prev = scl;
      sda_prev = sda;
      if (data_valid_o) begin
        chk(data_o == mem_byte(rx_cnt, salt), "R3 data byte", int'(data_o),
            int'(mem_byte(rx_cnt, salt)));
        chk(int'(data_index_o) == rx_cnt, "R3 index", int'(data_index_o), rx_cnt);
        rx_cnt++;
      end
      if (done_o) done_cnt++;
    end
  end

  task automatic run(input int n_set, input int nack, input int n_late);
    int n_eff;
    n_eff = (n_set == 0) ? 1 : n_set;
    rst_ni = 1'b0;
    byte_count_i = 16'(n_set);
    salt = 8'($urandom);
    nack_sel = nack;
    mode = M_IDLE; bitcnt = 0; ptr = 0; wn = 0; starts = 0; stops = 0;
    stops_at_rs = -1; macks = 0; mnacks = 0; rx_cnt = 0; done_cnt = 0;
    hi_cnt = 0; hi_bad = 0; falls_after_done = 0; mack = 0; rd_next = 0;
    first_hi = 1'b1; scl_prev = 1'b1; sda_prev = 1'b1; slave_low = 1'b0; sh = '0;
    for (int i = 0; i < 8; i++) wlog[i] = 8'hFF;
    repeat (3) @(negedge clk_i);
    chk(scl_o && !sda_oe_o && !data_valid_o && !done_o && !error_o,
        "R7 reset state", {scl_o, sda_oe_o, data_valid_o, done_o, error_o}, 5'b10000);
    rst_ni = 1'b1;
    if (n_late >= 0) begin
      repeat (30) @(negedge clk_i);
      byte_count_i = 16'(n_late);
    end
    for (int i = 0; i < 60000 && done_cnt == 0; i++) @(negedge clk_i);
    chk(done_cnt > 0, "R7 watchdog expired", done_cnt, 1);
    repeat (200) @(negedge clk_i);
    chk(done_cnt == 1, "R7 done pulses", done_cnt, 1);
    chk(falls_after_done == 0, "R7 bus quiet after done", falls_after_done, 0);
    chk(scl_o && !sda_oe_o, "R7 bus released", {scl_o, sda_oe_o}, 2'b10);
    chk(hi_bad == 0, "R9 SCL high width", hi_bad, 0);
    chk(stops == 1, "R8 single STOP", stops, 1);
    if (nack == 0) begin
      chk(wlog[0] == 8'hA0, "R1 device write byte", int'(wlog[0]), 'hA0);
      chk(wlog[1] == 8'h00, "R1 word address", int'(wlog[1]), 0);
      chk(wlog[2] == 8'hA1, "R2 device read byte", int'(wlog[2]), 'hA1);
      chk(wn == 3, "R2 master byte count", wn, 3);
      chk(stops_at_rs == 0, "R2 no STOP before repeated START", stops_at_rs, 0);
      chk(starts == 2, "R8 START count", starts, 2);
      chk(rx_cnt == n_eff, "R5 bytes delivered", rx_cnt, n_eff);
      chk(macks == n_eff - 1, "R4 master ACKs", macks, n_eff - 1);
      chk(mnacks == 1, "R4 final NACK", mnacks, 1);
      chk(!error_o, "R6 no error", int'(error_o), 0);
    end else begin
      chk(error_o, "R6 error raised", int'(error_o), 1);
      chk(rx_cnt == 0, "R6 no data", rx_cnt, 0);
      chk(wn == nack, "R6 stopped at failing byte", wn, nack);
      chk(starts == ((nack == 3) ? 2 : 1), "R8 START count on error", starts,
          (nack == 3) ? 2 : 1);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    run(1, 0, -1);
    run(2, 0, -1);
    run(0, 0, -1);
    run(3, 0, 9);
    run(5, 1, -1);
    run(5, 2, -1);
    run(5, 3, -1);
    for (int k = 0; k < 6; k++) run(1 + int'($urandom % 40), 0, -1);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule